// File: doc/BRIEF.md
# Register-File Write-Protection Guard

This block sits on the write path between a single-port register bus and the configuration registers of an eight-channel DMA controller. For every bus write it decides in the same cycle whether the write may reach its target. It holds a small mode register with a protection enable and a key check, and a status record made of a sticky violation flag and the word offset of the write that was refused.

While protection is on, a write aimed at any register in the guarded set is refused. The refusal is logged: the flag is set and the offset is captured. Writes to any other offset pass untouched. The flag can only be cleared by a write to the mode register that carries the correct 24-bit key in bits 31:8. Reads are never gated and do not enter the block. The register contents themselves live outside the block.

Word-offset map used by the guard: global configuration 0x00, controller enable 0x01, per-channel block at 0x10 + 8*ch for ch = 0..7 (eight guarded registers per channel: source address, destination address, descriptor address, two control words, channel configuration, source and destination picture-in-picture configuration), mode register 0x70, status register 0x71 (read-only).

Top module: `wpg_guard`

## Requirements
- R1: After synchronous reset, `prot_on`, `viol_flag` and `viol_src` are all zero.
- R2: A write to offset 0x70 whose data bits 31:8 equal 24'h3C96A5 loads data bit 0 into the enable, visible on `prot_on` in the next cycle.
- R3: While `prot_on` is 1, a write to a guarded offset drives `wr_allow` low in the same cycle.
- R4: A refused write sets `viol_flag` in the next cycle, and the flag stays set until a keyed write to 0x70.
- R5: A refused write loads its 16-bit word offset into `viol_src` in the next cycle; with several refusals, the most recent offset is held.
- R6: A write to 0x70 with any other key value changes neither `prot_on` nor `viol_flag` nor `viol_src`.
- R7: A keyed write to 0x70 clears `viol_flag` in the next cycle and leaves `viol_src` unchanged.
- R8: Writes to unguarded offsets (including 0x71, which has no effect on the status), and all writes while `prot_on` is 0, give `wr_allow` = 1 and leave the status unchanged.
- R9: The guarded set is exactly offsets 0x00, 0x01 and 0x10 through 0x4F; 0x02..0x0F and 0x50..0x6F are unguarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_off | input | 16 | Word offset of the write |
| wr_data | input | 32 | Write data |
| wr_allow | output | 1 | Write may reach its target register |
| prot_on | output | 1 | Protection enable state |
| viol_flag | output | 1 | Sticky violation flag |
| viol_src | output | 16 | Word offset of the latest refused write |

## Verification
Two functions of the guard land in one cycle whenever a refused write arrives while the flag is already set: the flag must hold and the offset must be overwritten, so the bench issues back-to-back refused writes to different guarded offsets and checks that only the newest offset survives. The second overlap is a keyed write that drops the enable followed at once by a guarded write, which must pass because the enable is a register whose new value governs the very next cycle. A behavioural model of enable, flag and offset runs beside the design and is compared on every clock, both in directed sequences and in a long stretch of random offsets mixed with right-key and wrong-key mode writes.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 32;
    localparam int KEY_W       = 24;
    localparam logic [KEY_W-1:0] WP_KEY = 24'h3C96A5;

    localparam int NUM_CH      = 8;
    localparam int REGS_PER_CH = 8;
    localparam int CH_STRIDE   = 8;
    localparam logic [31:0] OFF_CH_BASE = 32'h10;

    localparam logic [ADDR_W-1:0] OFF_GCFG = 16'h00;
    localparam logic [ADDR_W-1:0] OFF_GEN  = 16'h01;
    localparam logic [ADDR_W-1:0] OFF_MODE = 16'h70;
    localparam logic [ADDR_W-1:0] OFF_STAT = 16'h71;

    typedef enum logic [1:0] {
        CLS_OPEN = 2'd0,
        CLS_PROT = 2'd1,
        CLS_MODE = 2'd2,
        CLS_STAT = 2'd3
    } reg_cls_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] off;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] src;
    } wp_stat_t;

    function automatic logic key_ok(input logic [KEY_W-1:0] k);
        return k == WP_KEY;
    endfunction

endpackage

// File: rtl/wpg_decode.sv
module wpg_decode
    import wpg_pkg::*;
(
    input  logic [ADDR_W-1:0] off,
    output reg_cls_e          cls
);
    logic [NUM_CH-1:0] ch_hit;
    logic [31:0]       off_w;

    assign off_w = 32'(off);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [31:0] LO = OFF_CH_BASE + 32'(c * CH_STRIDE);
        localparam logic [31:0] HI = LO + 32'(REGS_PER_CH);
        assign ch_hit[c] = (off_w >= LO) && (off_w < HI);
    end

    always_comb begin
        if (off == OFF_GCFG || off == OFF_GEN || (|ch_hit))
            cls = CLS_PROT;
        else if (off == OFF_MODE)
            cls = CLS_MODE;
        else if (off == OFF_STAT)
            cls = CLS_STAT;
        else
            cls = CLS_OPEN;
    end
endmodule

// File: rtl/wpg_mode_reg.sv
module wpg_mode_reg
    import wpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_cls_e         cls,
    input  logic [KEY_W-1:0] key_in,
    input  logic             en_in,
    output logic             prot_on,
    output logic             keyed_wr
);
    assign keyed_wr = wr_en && (cls == CLS_MODE) && key_ok(key_in);

    always_ff @(posedge clk) begin
        if (rst)
            prot_on <= 1'b0;
        else if (keyed_wr)
            prot_on <= en_in;
    end

    AST_WRONG_KEY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cls == CLS_MODE && !key_ok(key_in)) |=> $stable(prot_on)); // R6
endmodule

// File: rtl/wpg_status.sv
module wpg_status
    import wpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              block,
    input  logic [ADDR_W-1:0] blk_off,
    input  logic              clr,
    output wp_stat_t          stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (block) begin
            stat.flag <= 1'b1;
            stat.src  <= blk_off;
        end else if (clr) begin
            stat.flag <= 1'b0;
        end
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        block |=> stat.flag); // R4
    AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        block |=> stat.src == $past(blk_off)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat.flag && !clr) |=> stat.flag); // R4
    AST_CLEAR_KEEPS_SRC: assert property (@(posedge clk) disable iff (rst)
        (clr && !block) |=> (!stat.flag && $stable(stat.src))); // R7
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
    import wpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_off,
    input  logic [31:0] wr_data,
    output logic        wr_allow,
    output logic        prot_on,
    output logic        viol_flag,
    output logic [15:0] viol_src
);
    wr_req_t  req;
    reg_cls_e cls;
    logic     keyed_wr;
    logic     blocked;
    wp_stat_t stat;
    logic     unused_mode_bits;

    assign req = '{en: wr_en, off: wr_off, data: wr_data};
    assign unused_mode_bits = ^req.data[DATA_W-KEY_W-1:1];

    wpg_decode u_decode (
        .off (req.off),
        .cls (cls)
    );

    wpg_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req.en),
        .cls      (cls),
        .key_in   (req.data[DATA_W-1 -: KEY_W]),
        .en_in    (req.data[0]),
        .prot_on  (prot_on),
        .keyed_wr (keyed_wr)
    );

    assign blocked  = req.en && (cls == CLS_PROT) && prot_on;
    assign wr_allow = req.en && !blocked;

    wpg_status u_status (
        .clk     (clk),
        .rst     (rst),
        .block   (blocked),
        .blk_off (req.off),
        .clr     (keyed_wr),
        .stat    (stat)
    );

    assign viol_flag = stat.flag;
    assign viol_src  = stat.src;

    AST_PROT_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && prot_on && cls == CLS_PROT) |-> !wr_allow); // R3
    AST_OFF_PASSES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !prot_on) |-> wr_allow); // R8
    AST_OPEN_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (cls == CLS_OPEN || cls == CLS_STAT)) |=> ($stable(viol_flag) && $stable(viol_src))); // R8
    AST_GLOBAL_GUARDED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && prot_on && wr_off <= 16'h01) |-> !wr_allow); // R9
    AST_BAD_KEY_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == OFF_MODE && wr_data[31:8] != WP_KEY)
            |=> ($stable(viol_flag) && $stable(viol_src))); // R6
endmodule

// File: tb/wpg_guard_bench.sv
`timescale 1ns/1ps
module wpg_guard_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_off;
    logic [31:0] wr_data;
    logic        wr_allow, prot_on, viol_flag;
    logic [15:0] viol_src;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [23:0] GOOD_KEY = 24'h3C96A5;

    bit          m_en;
    bit          m_flag;
    logic [15:0] m_src;

    always #2 clk = ~clk;

    wpg_guard u_wpg_guard (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .wr_allow(wr_allow), .prot_on(prot_on), .viol_flag(viol_flag), .viol_src(viol_src)
    );

    function automatic bit guarded(input logic [15:0] a);
        int ai = int'(a);
        if (ai == 0 || ai == 1) return 1;
        for (int c = 0; c < 8; c++)
            if (ai >= 16 + 8 * c && ai <= 16 + 8 * c + 7) return 1;
        return 0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_state(input string tag);
        chk(tag, "prot_on", 32'(prot_on), 32'(m_en));
        chk(tag, "viol_flag", 32'(viol_flag), 32'(m_flag));
        chk(tag, "viol_src", 32'(viol_src), 32'(m_src));
    endtask

    // drive one cycle, check allow combinationally, then state after the edge
    task automatic step(input string tag, input bit we, input logic [15:0] a, input logic [31:0] d);
        bit exp_allow;
        @(negedge clk);
        wr_en = we; wr_off = a; wr_data = d;
        #0.5;
        exp_allow = we && !(m_en && guarded(a));
        chk(tag, "wr_allow", 32'(wr_allow), 32'(exp_allow));
        @(posedge clk);
        if (we && a == 16'h70 && d[31:8] == GOOD_KEY) begin
            m_en = d[0];
            m_flag = 0;
        end else if (we && m_en && guarded(a)) begin
            m_flag = 1;
            m_src = a;
        end
        #0.5;
        cmp_state(tag);
    endtask

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_off = 0; wr_data = 0;
        m_en = 0; m_flag = 0; m_src = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        cmp_state("R1");

        // protection off: guarded writes pass
        step("R8", 1, 16'h00, 32'h1);
        step("R8", 1, 16'h4F, 32'h1);
        // wrong key cannot enable
        step("R6", 1, 16'h70, {24'h3C96A4, 8'h01});
        step("R6", 1, 16'h70, {24'h000000, 8'h01});
        // right key enables
        step("R2", 1, 16'h70, {GOOD_KEY, 8'h01});
        chk("R2", "prot_on after keyed enable", 32'(prot_on), 32'd1);
        // refusals
        step("R3", 1, 16'h00, 32'hA);
        chk("R4", "flag after refusal", 32'(viol_flag), 32'd1);
        chk("R5", "src after refusal", 32'(viol_src), 32'h00);
        step("R9", 1, 16'h01, 32'hA);
        step("R9", 1, 16'h4F, 32'hB);
        chk("R5", "latest src", 32'(viol_src), 32'h4F);
        step("R9", 1, 16'h02, 32'h0);
        step("R9", 1, 16'h0F, 32'h0);
        step("R9", 1, 16'h50, 32'h0);
        step("R9", 1, 16'h6F, 32'h0);
        step("R9", 1, 16'h10, 32'h0);
        step("R9", 1, 16'h2B, 32'h0);
        chk("R5", "src mid-channel", 32'(viol_src), 32'h2B);
        // status write has no effect
        step("R8", 1, 16'h71, 32'hFFFF_FFFF);
        chk("R8", "src kept after status write", 32'(viol_src), 32'h2B);
        // wrong key cannot clear
        step("R6", 1, 16'h70, {24'hC3696A, 8'h00});
        chk("R6", "flag kept on wrong key", 32'(viol_flag), 32'd1);
        // keyed clear keeping enable
        step("R7", 1, 16'h70, {GOOD_KEY, 8'h01});
        chk("R7", "flag cleared", 32'(viol_flag), 32'd0);
        chk("R7", "src retained", 32'(viol_src), 32'h2B);
        // disable then guarded write passes on the very next cycle
        step("R2", 1, 16'h70, {GOOD_KEY, 8'h00});
        step("R8", 1, 16'h18, 32'h5);
        chk("R8", "no flag when off", 32'(viol_flag), 32'd0);
        // idle cycles
        step("R4", 0, 16'h00, 32'h0);

        // random mix compared every clock
        for (int i = 0; i < 400; i++) begin
            int sel = int'($urandom_range(0, 9));
            logic [15:0] a = 16'($urandom_range(0, 16'h7F));
            logic [31:0] d = $urandom;
            if (sel == 0) begin
                a = 16'h70; d = {GOOD_KEY, 7'h0, d[0]};
            end else if (sel == 1) begin
                a = 16'h70;
            end
            step("R5", sel != 9, a, d);
        end

        // reset again mid-run
        @(negedge clk); rst = 1;
        @(posedge clk); #0.5;
        m_en = 0; m_flag = 0; m_src = 0;
        @(negedge clk); rst = 0;
        cmp_state("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule